// File: doc/BRIEF.md
# Low-Speed Clock Domain Control Register

This block is the control and status register of a battery-backed timekeeping clock domain. Software writes one word over a simple write strobe and data bus. It reads the full state back at any time on a read bus. The register enables a low-speed external oscillator and reports when that oscillator is ready. It holds a bypass bit and a drive-strength code, and picks the clock source for the timekeeper. It also gates the low-speed clock to system logic, enables the timekeeper clock, and holds the whole domain in a software reset.

All logic runs on the fast system clock. The low-speed oscillator arrives as a free-running input. A two-flop synchroniser and an edge detector turn it into one-cycle ticks. Every low-speed delay is a count of those ticks. A supervisor counts fast cycles between ticks and latches a failure flag when the low-speed clock stops. Several fields are protected by hardware rules: a source select that can be written once, a bypass bit that can only change while the oscillator is fully off, and a supervision enable that cannot be cleared until a failure has been seen.

Top module: `lsdom_ctrl`

## Requirements
- R1: After reset every bit of `bus_rdata` is 0 and every output is 0.
- R2: With the enable (bit 0) at 1, the ready flag (bit 1) rises on the START_EDGES-th low-speed rising edge counted after the enable was written, and not before.
- R3: After the enable is written to 0, the ready flag stays 1 through the fifth low-speed rising edge and is 0 after the sixth.
- R4: A write to the bypass bit (bit 2) takes effect only while both the enable and the ready flag are 0. Otherwise the bit keeps its value.
- R5: The drive code (bits 4:3) is stored and read back as written. `osc_drive_o` equals the code while bypass is 0 and is 0 while bypass is 1.
- R6: A write of 1 to the supervision enable (bit 5) takes effect only while the enable is 1, the ready flag is 1 and the current source select is nonzero. Otherwise the bit stays 0.
- R7: Once the supervision enable is 1, a write of 0 clears it only while the failure flag is 1.
- R8: The failure flag (bit 6) is set by hardware when the supervision enable is 1 and no low-speed edge arrives for FAIL_WINDOW fast cycles. The ready flag, the failure flag and the system-ready flag (bit 10) ignore software writes.
- R9: The source select (bits 9:8) can be written only while it reads 00 or while the failure flag is 1. Other writes leave it unchanged.
- R10: A write with the domain reset bit (bit 16) at 1 clears every other field and flag on the same edge. While the bit stays 1, writes change nothing else, and only bit 16 reads back as 1.
- R11: With the system enable (bit 7), the enable and the ready flag all at 1, the system-ready flag rises on the second low-speed rising edge. It is 0 on the cycle after any of those three conditions goes false.
- R12: The timekeeper clock enable (bit 11) is a plain read/write bit that drives `tk_clk_en_o`. Bits not named above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read image |
| ls_clk_in | input | 1 | Low-speed oscillator clock, asynchronous to clk |
| osc_en_o | output | 1 | Oscillator enable |
| osc_bypass_o | output | 1 | Oscillator bypass |
| osc_drive_o | output | 2 | Effective drive code, 0 in bypass |
| tk_src_o | output | 2 | Timekeeper clock source select |
| tk_clk_en_o | output | 1 | Timekeeper clock enable |
| ls_sys_gate_o | output | 1 | Low-speed clock released to the system |
| clk_fail_o | output | 1 | Low-speed clock failure detected |
| dom_rst_o | output | 1 | Domain software reset held |

## Verification
Most wrong internal states show in `bus_rdata` one cycle after the write that caused them. Examples are a lock that fails to hold, a sticky bit that clears, or a source that can be rewritten. The bench therefore compares the whole image after every write. A wrong tick counter shows only in the edge on which a ready flag changes. It appears as an off-by-one edge, which the bench finds by sampling one edge before and one edge at the expected count. A supervisor that fails to trip shows FAIL_WINDOW cycles after the low-speed clock stops, once `clk_fail_o` stays low. A supervisor that trips falsely sets `clk_fail_o` during normal low-speed traffic.

// File: rtl/lsdom_pkg.sv
package lsdom_pkg;
  // Bit positions of the register image
  localparam int B_OSC_EN  = 0;
  localparam int B_OSC_RDY = 1;
  localparam int B_BYP     = 2;
  localparam int B_DRV     = 3;   // two bits
  localparam int B_SUP_EN  = 5;
  localparam int B_FAIL    = 6;
  localparam int B_SYS_EN  = 7;
  localparam int B_SRC     = 8;   // two bits
  localparam int B_SYS_RDY = 10;
  localparam int B_TK_EN   = 11;
  localparam int B_DOM_RST = 16;
  localparam int MIN_DATA_W = B_DOM_RST + 1;

  typedef struct packed {
    logic       dom_rst;
    logic       tk_en;
    logic [1:0] src;
    logic       sys_en;
    logic       sup_en;
    logic [1:0] drv;
    logic       byp;
    logic       osc_en;
  } lsdom_ctl_t;
endpackage

// File: rtl/lsdom_edge_sync.sv
module lsdom_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic tick
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign tick = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lsdom_osc_ready.sv
module lsdom_osc_ready #(
  parameter int START_EDGES = 16,
  parameter int STOP_EDGES  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic rdy
);
  localparam int MAXE = (START_EDGES > STOP_EDGES) ? START_EDGES : STOP_EDGES;
  localparam int CW   = $clog2(MAXE + 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_EDGES - 1);
  localparam logic [CW-1:0] STOP_LAST  = CW'(STOP_EDGES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rdy   <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      if (rdy) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == START_LAST) begin
          rdy   <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin
      if (!rdy) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == STOP_LAST) begin
          rdy   <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsdom_sys_ready.sv
module lsdom_sys_ready #(
  parameter int EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cond,
  input  logic tick,
  output logic rdy
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !cond) begin
      rdy   <= 1'b0;
      cnt_q <= '0;
    end else if (tick && !rdy) begin
      if (cnt_q == LAST) begin
        rdy   <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsdom_fail_wdog.sv
module lsdom_fail_wdog #(
  parameter int WINDOW = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic tick,
  output logic fail
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail  <= 1'b0;
      gap_q <= '0;
    end else if (!arm || fail || tick) begin
      gap_q <= '0;
    end else if (gap_q == LAST) begin
      fail  <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/lsdom_ctrl.sv
module lsdom_ctrl
  import lsdom_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int START_EDGES  = 16,
  parameter int STOP_EDGES   = 6,
  parameter int SYSRDY_EDGES = 2,
  parameter int FAIL_WINDOW  = 48,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ls_clk_in,
  output logic              osc_en_o,
  output logic              osc_bypass_o,
  output logic [1:0]        osc_drive_o,
  output logic [1:0]        tk_src_o,
  output logic              tk_clk_en_o,
  output logic              ls_sys_gate_o,
  output logic              clk_fail_o,
  output logic              dom_rst_o
);
  lsdom_ctl_t ctl_q;
  logic       ls_tick;
  logic       osc_rdy;
  logic       sys_rdy;
  logic       fail;
  logic       dom_hold;
  logic       byp_open;
  logic       src_open;
  logic       sup_next;
  logic       unused_wbits;

  assign unused_wbits = ^bus_wdata;

  // Domain reset wins on the edge it is written and while it stays set
  assign dom_hold = ctl_q.dom_rst | (bus_wr & bus_wdata[B_DOM_RST]);
  assign byp_open = ~ctl_q.osc_en & ~osc_rdy;
  assign src_open = (ctl_q.src == 2'b00) | fail;
  assign sup_next = ctl_q.sup_en
                  ? (fail ? bus_wdata[B_SUP_EN] : 1'b1)
                  : (bus_wdata[B_SUP_EN] & ctl_q.osc_en & osc_rdy & (ctl_q.src != 2'b00));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (dom_hold) begin
      ctl_q         <= '0;
      ctl_q.dom_rst <= bus_wr ? bus_wdata[B_DOM_RST] : 1'b1;
    end else if (bus_wr) begin
      ctl_q.osc_en <= bus_wdata[B_OSC_EN];
      if (byp_open) ctl_q.byp <= bus_wdata[B_BYP];
      ctl_q.drv    <= bus_wdata[B_DRV +: 2];
      ctl_q.sup_en <= sup_next;
      ctl_q.sys_en <= bus_wdata[B_SYS_EN];
      if (src_open) ctl_q.src <= bus_wdata[B_SRC +: 2];
      ctl_q.tk_en  <= bus_wdata[B_TK_EN];
    end
  end

  lsdom_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ls_clk_in), .tick(ls_tick)
  );

  lsdom_osc_ready #(.START_EDGES(START_EDGES), .STOP_EDGES(STOP_EDGES)) u_osc (
    .clk(clk), .rst(rst), .clr(dom_hold), .en(ctl_q.osc_en), .tick(ls_tick), .rdy(osc_rdy)
  );

  lsdom_sys_ready #(.EDGES(SYSRDY_EDGES)) u_sysrdy (
    .clk(clk), .rst(rst), .clr(dom_hold),
    .cond(ctl_q.sys_en & ctl_q.osc_en & osc_rdy),
    .tick(ls_tick), .rdy(sys_rdy)
  );

  lsdom_fail_wdog #(.WINDOW(FAIL_WINDOW)) u_wdog (
    .clk(clk), .rst(rst), .clr(dom_hold), .arm(ctl_q.sup_en), .tick(ls_tick), .fail(fail)
  );

  always_comb begin
    bus_rdata                 = '0;
    bus_rdata[B_OSC_EN]       = ctl_q.osc_en;
    bus_rdata[B_OSC_RDY]      = osc_rdy;
    bus_rdata[B_BYP]          = ctl_q.byp;
    bus_rdata[B_DRV +: 2]     = ctl_q.drv;
    bus_rdata[B_SUP_EN]       = ctl_q.sup_en;
    bus_rdata[B_FAIL]         = fail;
    bus_rdata[B_SYS_EN]       = ctl_q.sys_en;
    bus_rdata[B_SRC +: 2]     = ctl_q.src;
    bus_rdata[B_SYS_RDY]      = sys_rdy;
    bus_rdata[B_TK_EN]        = ctl_q.tk_en;
    bus_rdata[B_DOM_RST]      = ctl_q.dom_rst;
  end

  assign osc_en_o      = ctl_q.osc_en;
  assign osc_bypass_o  = ctl_q.byp;
  assign osc_drive_o   = ctl_q.byp ? 2'b00 : ctl_q.drv;
  assign tk_src_o      = ctl_q.src;
  assign tk_clk_en_o   = ctl_q.tk_en;
  assign ls_sys_gate_o = sys_rdy;
  assign clk_fail_o    = fail;
  assign dom_rst_o     = ctl_q.dom_rst;
endmodule

// File: rtl/lsdom_ctrl_chk.sv
module lsdom_ctrl_chk
  import lsdom_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              osc_en,
  input logic              osc_rdy,
  input logic              byp,
  input logic              sup_en,
  input logic              fail,
  input logic              sys_en,
  input logic [1:0]        src,
  input logic              sys_rdy,
  input logic              tk_en,
  input logic              dom_rst
);
  logic dom_wr;
  assign dom_wr = bus_wr & bus_wdata[B_DOM_RST];

  assert_byp_lock_R4: assert property (@(posedge clk) disable iff (rst)
    ((osc_en || osc_rdy) && !dom_wr) |=> $stable(byp));

  assert_sup_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (!sup_en && !(osc_en && osc_rdy && (src != 2'b00))) |=> !sup_en);

  assert_sup_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (sup_en && !fail && !dom_wr) |=> sup_en);

  assert_fail_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(sup_en));

  assert_src_once_R9: assert property (@(posedge clk) disable iff (rst)
    ((src != 2'b00) && !fail && !dom_wr) |=> $stable(src));

  assert_dom_hold_R10: assert property (@(posedge clk) disable iff (rst)
    dom_rst |-> (!osc_en && !byp && !sup_en && !sys_en && (src == 2'b00) && !tk_en
                 && !osc_rdy && !fail && !sys_rdy));

  assert_sys_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (!sys_en || !osc_en || !osc_rdy) |=> !sys_rdy);
endmodule

bind lsdom_ctrl lsdom_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .osc_en(ctl_q.osc_en), .osc_rdy(osc_rdy), .byp(ctl_q.byp), .sup_en(ctl_q.sup_en),
  .fail(fail), .sys_en(ctl_q.sys_en), .src(ctl_q.src), .sys_rdy(sys_rdy),
  .tk_en(ctl_q.tk_en), .dom_rst(ctl_q.dom_rst)
);

// File: tb/tb_lsdom_ctrl.sv
module tb_lsdom_ctrl;
  localparam int DW      = 32;
  localparam int START   = 16;
  localparam int WINDOW  = 48;
  localparam int LS_HALF = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          ls_clk_in = 1'b0;
  logic          osc_en_o, osc_bypass_o, tk_clk_en_o, ls_sys_gate_o, clk_fail_o, dom_rst_o;
  logic [1:0]    osc_drive_o, tk_src_o;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] expv = '0;

  always #2 clk = ~clk;

  lsdom_ctrl #(.DATA_W(DW), .START_EDGES(START), .FAIL_WINDOW(WINDOW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ls_clk_in(ls_clk_in), .osc_en_o(osc_en_o), .osc_bypass_o(osc_bypass_o),
    .osc_drive_o(osc_drive_o), .tk_src_o(tk_src_o), .tk_clk_en_o(tk_clk_en_o),
    .ls_sys_gate_o(ls_sys_gate_o), .clk_fail_o(clk_fail_o), .dom_rst_o(dom_rst_o)
  );

  // Expected register image after a write, from the requirements
  function automatic logic [DW-1:0] model(input logic [DW-1:0] c, input logic [DW-1:0] w);
    logic [DW-1:0] n;
    n = '0;
    if (c[16] || w[16]) begin
      n[16] = w[16];
    end else begin
      n[0]   = w[0];
      n[1]   = c[1];
      n[2]   = (!c[0] && !c[1]) ? w[2] : c[2];
      n[4:3] = w[4:3];
      n[5]   = c[5] ? (c[6] ? w[5] : 1'b1) : (w[5] & c[0] & c[1] & (c[9:8] != 2'b00));
      n[6]   = c[6];
      n[7]   = w[7];
      n[9:8] = ((c[9:8] == 2'b00) || c[6]) ? w[9:8] : c[9:8];
      n[10]  = c[10];
      n[11]  = w[11];
    end
    return n;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    expv = model(expv, d);
  endtask

  task automatic ls_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ls_clk_in = 1'b1;
      repeat (LS_HALF) @(negedge clk);
      ls_clk_in = 1'b0;
      repeat (LS_HALF) @(negedge clk);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, bus_rdata, expv);
    chk(req, {30'd0, osc_drive_o}, {30'd0, (expv[2] ? 2'b00 : expv[4:3])});
    chk(req, {28'd0, osc_bypass_o, tk_clk_en_o, tk_src_o}, {28'd0, expv[2], expv[11], expv[9:8]});
    chk(req, {28'd0, osc_en_o, clk_fail_o, ls_sys_gate_o, dom_rst_o},
        {28'd0, expv[0], expv[6], expv[10], expv[16]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_outs("R1 reset state");

    // Read-only flags ignore writes
    wr(32'h0000_0442);
    chk_outs("R8 read-only flags");

    // Bypass open while oscillator off; drive masked in bypass
    wr(32'h0000_0014);
    chk_outs("R4/R5 bypass set, drive masked");
    wr(32'h0000_0018);
    chk_outs("R5 drive readback");

    // Supervision cannot be set with oscillator off
    wr(32'h0000_0038);
    chk_outs("R6 supervision ignored when off");

    // Oscillator startup
    wr(32'h0000_0001);
    ls_edges(START - 1);
    chk_outs("R2 ready still low one edge early");
    ls_edges(1);
    expv[1] = 1'b1;
    chk_outs("R2 ready high at count");

    wr(32'h0000_0005);
    chk_outs("R4 bypass locked when on");

    wr(32'h0000_0021);
    chk_outs("R6 supervision ignored without source");
    wr(32'h0000_0101);
    chk_outs("R9 first source write");
    wr(32'h0000_0201);
    chk_outs("R9 source write-once");
    wr(32'h0000_0121);
    chk_outs("R6 supervision accepted");

    // System-ready release
    wr(32'h0000_01A1);
    ls_edges(1);
    chk_outs("R11 system ready low after one edge");
    ls_edges(1);
    expv[10] = 1'b1;
    chk_outs("R11 system ready after two edges");
    wr(32'h0000_0121);
    @(negedge clk);
    expv[10] = 1'b0;
    chk_outs("R11 system ready drops with enable");

    wr(32'h0000_0101);
    chk_outs("R7 supervision sticky");

    // Stop the low-speed clock
    repeat (WINDOW + 8) @(negedge clk);
    expv[6] = 1'b1;
    chk_outs("R8 failure detected");
    wr(32'h0000_0321);
    chk_outs("R9 source rewritable after failure");
    wr(32'h0000_0301);
    chk_outs("R7 supervision clears after failure");

    // Oscillator shutdown
    wr(32'h0000_0300);
    ls_edges(5);
    chk_outs("R3 ready held five edges");
    ls_edges(1);
    expv[1] = 1'b0;
    chk_outs("R3 ready low at sixth edge");

    // Domain reset
    wr(32'h0001_0A85);
    chk_outs("R10 domain reset clears all");
    wr(32'h0001_0391);
    chk_outs("R10 fields held during reset");
    wr(32'h0000_0000);
    chk_outs("R10 reset released");
    wr(32'h0000_0800);
    chk_outs("R12 timekeeper enable");

    // Random writes with the oscillator kept off
    for (int i = 0; i < 200; i++) begin
      w = $urandom;
      w[0] = 1'b0;
      w[16] = (($urandom % 8) == 0);
      wr(w);
      chk_outs("R4/R5/R9/R10/R12 random write");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule